// File: doc/BRIEF.md
# Peer Setup Message Sequencer

This block sits behind the byte stream from a control server that hands out peer notification handles. Bytes arrive one per valid beat. A sideband flag says whether a handle came with the current message. The block gathers every eight bytes into a signed 64-bit word, least significant byte first, and runs a fixed setup dialogue on those words.

The dialogue has three stages. The first word is a protocol version check. The second word assigns this node's own identifier. After that, a stream of peer updates follows, and it is closed by a shared-memory announcement.

Each peer update is either a connect or a disconnect. A connect carries a handle, and the block hands it the next free vector number of that peer. Vector numbers never travel on the wire. A disconnect carries no handle, and it releases all vectors of that peer. The block reports each accepted update as a one-cycle event with the peer and the vector. It also keeps a sticky error flag with a code, a setup-complete flag, the assigned identifier and the master decision.

Top module: `peer_setup_seq`

## Requirements
- R1: A message is the 8 bytes of consecutive `in_valid` beats, assembled least significant byte first. Idle cycles between beats are allowed. `in_handle` is sampled only on the eighth beat.
- R2: The first message must equal `PROTO_VER` and carry no handle. Otherwise error code 1 is raised and the block stops for good: it produces no further events and never sets `setup_done`.
- R3: The second message sets `own_id`. It must carry no handle and lie in 0..65535. Otherwise error code 2 is raised, which is fatal in the same way as R2.
- R4: `master_mode` is sampled when the identifier is accepted. Encoding: 0 = off, 1 = forced on, 2 = automatic.
  - Forced on with an identifier other than 0 raises fatal code 2.
  - `is_master` is 1 when the mode is forced on, or when the mode is automatic and the identifier is 0. It is 0 otherwise.
- R5: After the identifier, the value -1 sets `setup_done`, which then stays 1. A second -1 raises code 6.
- R6: In the peer stage, any value below -1 or above 65535 raises code 3. It has no other effect.
- R7: A peer message with the handle flag is a connect. The block pulses `conn_valid` for one cycle with `ev_peer` = the index and `ev_vector` = that peer's vector count before the message. The count then increments.
- R8: A connect to a peer whose count already equals `NVEC` raises code 4. It produces no event and leaves the count unchanged. Later messages are still processed.
- R9: A peer message without the handle is a disconnect. It pulses `disc_valid` with `ev_peer` = the index and `ev_vector` = 0, and clears that peer's count. If the index equals `own_id`, the block raises code 5 instead, with no event.
- R10: A peer index of `NPEER` or more raises code 7. It produces no event and causes no table growth.
- R11: `peer_count` resets to 0. An accepted-range peer index at or above it sets it to index+1. It never decreases.
- R12: `err_flag` is sticky. `err_code` keeps the first error raised. Errors other than codes 1 and 2 do not stop processing.
- R13: `conn_valid` and `disc_valid` are low in reset and are never high together. Events appear only for peer-stage messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 2 | 0 off, 1 forced on, 2 automatic |
| in_valid | input | 1 | Byte beat valid |
| in_byte | input | 8 | Stream byte |
| in_handle | input | 1 | Handle present, sampled on the final beat |
| setup_done | output | 1 | Shared-memory announcement received |
| is_master | output | 1 | Master decision |
| own_id | output | 16 | Assigned identifier |
| peer_count | output | clog2(NPEER+1) | Current peer table size |
| err_flag | output | 1 | Sticky error |
| err_code | output | 3 | First error code |
| conn_valid | output | 1 | Connect event strobe |
| disc_valid | output | 1 | Disconnect event strobe |
| ev_peer | output | clog2(NPEER) | Event peer index |
| ev_vector | output | clog2(NVEC) | Event vector number |

## Verification
The bench builds the block with `NPEER` = 4 and `NVEC` = 2. With these values, the two-vector overflow, the capacity rejection at index 9 and a table that grows to its full size can each be reached in a handful of messages. The identifier 258 checks the byte order, since it differs from its byte-swapped value. The bench gives every fatal path and every non-fatal code its own reset, so that each code is the first one seen and the sticky rule can be observed against a later error.

// File: rtl/pss_pkg.sv
package pss_pkg;
  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_VERSION    = 3'd1,
    ERR_IDENT      = 3'd2,
    ERR_RANGE      = 3'd3,
    ERR_VEC_FULL   = 3'd4,
    ERR_DISCONNECT = 3'd5,
    ERR_DUP_SHMEM  = 3'd6,
    ERR_CAPACITY   = 3'd7
  } err_e;

  typedef enum logic [2:0] {
    ST_VER, ST_ID, ST_PEERS, ST_READY, ST_FAIL
  } phase_e;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_ON   = 2'd1,
    MODE_AUTO = 2'd2
  } master_e;

  typedef struct packed {
    logic        shmem;
    logic        bad_range;
    logic        over_cap;
    logic [15:0] idx;
  } msg_class_t;
endpackage

// File: rtl/pss_msg_assembler.sv
module pss_msg_assembler #(
  parameter int MSG_BYTES = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [7:0]             in_byte,
  input  logic                   in_handle,
  output logic                   msg_valid,
  output logic [8*MSG_BYTES-1:0] msg_data,
  output logic                   msg_handle
);
  localparam int MW = 8 * MSG_BYTES;
  localparam int BW = (MSG_BYTES > 1) ? $clog2(MSG_BYTES) : 1;

  logic [BW-1:0] beat;
  logic [MW-1:0] shreg;
  logic          last;

  assign last = (beat == BW'(MSG_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      beat       <= '0;
      shreg      <= '0;
      msg_valid  <= 1'b0;
      msg_data   <= '0;
      msg_handle <= 1'b0;
    end else begin
      msg_valid <= 1'b0;
      if (in_valid) begin
        shreg <= {in_byte, shreg[MW-1:8]};
        if (last) begin
          beat       <= '0;
          msg_valid  <= 1'b1;
          msg_data   <= {in_byte, shreg[MW-1:8]};
          msg_handle <= in_handle;
        end else begin
          beat <= beat + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pss_msg_classifier.sv
module pss_msg_classifier
  import pss_pkg::*;
#(
  parameter int NPEER = 16
) (
  input  logic [63:0] msg,
  output msg_class_t  cls
);
  always_comb begin
    cls.shmem     = &msg;
    cls.bad_range = msg[63] ? !(&msg) : (|msg[62:16]);
    cls.idx       = msg[15:0];
    cls.over_cap  = (32'(msg[15:0]) >= NPEER);
  end
endmodule

// File: rtl/pss_vec_table.sv
module pss_vec_table #(
  parameter int NPEER = 16,
  parameter int CW    = 4,
  parameter int PW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] rd_idx,
  output logic [CW-1:0] rd_cnt,
  input  logic          we,
  input  logic [PW-1:0] wr_idx,
  input  logic [CW-1:0] wr_cnt
);
  logic [CW-1:0] cnt_arr [NPEER];

  for (genvar g = 0; g < NPEER; g++) begin : g_entry
    logic [CW-1:0] entry;
    always_ff @(posedge clk) begin
      if (rst) begin
        entry <= '0;
      end else if (we && (wr_idx == PW'(g))) begin
        entry <= wr_cnt;
      end
    end
    assign cnt_arr[g] = entry;
  end

  assign rd_cnt = cnt_arr[rd_idx];
endmodule

// File: rtl/peer_setup_seq.sv
module peer_setup_seq
  import pss_pkg::*;
#(
  parameter int          NPEER     = 16,
  parameter int          NVEC      = 8,
  parameter logic [63:0] PROTO_VER = 64'd0,
  localparam int PW = (NPEER > 1) ? $clog2(NPEER) : 1,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int TW = $clog2(NPEER + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    master_mode,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_handle,
  output logic          setup_done,
  output logic          is_master,
  output logic [15:0]   own_id,
  output logic [TW-1:0] peer_count,
  output logic          err_flag,
  output logic [2:0]    err_code,
  output logic          conn_valid,
  output logic          disc_valid,
  output logic [PW-1:0] ev_peer,
  output logic [VW-1:0] ev_vector
);
  localparam int CW = $clog2(NVEC + 1);

  logic        msg_valid;
  logic [63:0] msg_data;
  logic        msg_handle;
  msg_class_t  cls;
  phase_e      phase, phase_n;
  logic [PW-1:0] idx_p;
  logic [CW-1:0] rd_cnt;
  logic [CW-1:0] wr_cnt;
  logic        raise, conn_ok, disc_ok, grow, id_load;
  err_e        code;

  pss_msg_assembler #(.MSG_BYTES(8)) u_asm (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_handle(in_handle), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_handle(msg_handle)
  );

  pss_msg_classifier #(.NPEER(NPEER)) u_cls (
    .msg(msg_data), .cls(cls)
  );

  assign idx_p  = cls.idx[PW-1:0];
  assign wr_cnt = conn_ok ? rd_cnt + 1'b1 : '0;

  pss_vec_table #(.NPEER(NPEER), .CW(CW), .PW(PW)) u_tbl (
    .clk(clk), .rst(rst), .rd_idx(idx_p), .rd_cnt(rd_cnt),
    .we(conn_ok || disc_ok), .wr_idx(idx_p), .wr_cnt(wr_cnt)
  );

  always_comb begin
    raise   = 1'b0;
    code    = ERR_NONE;
    phase_n = phase;
    conn_ok = 1'b0;
    disc_ok = 1'b0;
    grow    = 1'b0;
    id_load = 1'b0;
    if (msg_valid) begin
      case (phase)
        ST_VER: begin
          if (msg_handle || (msg_data != PROTO_VER)) begin
            raise = 1'b1; code = ERR_VERSION; phase_n = ST_FAIL;
          end else begin
            phase_n = ST_ID;
          end
        end
        ST_ID: begin
          if (msg_handle || msg_data[63] || (|msg_data[62:16]) ||
              ((master_mode == MODE_ON) && (msg_data[15:0] != 16'd0))) begin
            raise = 1'b1; code = ERR_IDENT; phase_n = ST_FAIL;
          end else begin
            id_load = 1'b1; phase_n = ST_PEERS;
          end
        end
        ST_PEERS, ST_READY: begin
          if (cls.shmem) begin
            if (phase == ST_READY) begin
              raise = 1'b1; code = ERR_DUP_SHMEM;
            end else begin
              phase_n = ST_READY;
            end
          end else if (cls.bad_range) begin
            raise = 1'b1; code = ERR_RANGE;
          end else if (cls.over_cap) begin
            raise = 1'b1; code = ERR_CAPACITY;
          end else begin
            grow = (32'(cls.idx) >= 32'(peer_count));
            if (msg_handle) begin
              if (rd_cnt == CW'(NVEC)) begin
                raise = 1'b1; code = ERR_VEC_FULL;
              end else begin
                conn_ok = 1'b1;
              end
            end else if (cls.idx == own_id) begin
              raise = 1'b1; code = ERR_DISCONNECT;
            end else begin
              disc_ok = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= ST_VER;
      setup_done <= 1'b0;
      is_master  <= 1'b0;
      own_id     <= '0;
      peer_count <= '0;
      err_flag   <= 1'b0;
      err_code   <= ERR_NONE;
      conn_valid <= 1'b0;
      disc_valid <= 1'b0;
      ev_peer    <= '0;
      ev_vector  <= '0;
    end else begin
      phase      <= phase_n;
      conn_valid <= conn_ok;
      disc_valid <= disc_ok;
      if (conn_ok || disc_ok) begin
        ev_peer   <= idx_p;
        ev_vector <= conn_ok ? VW'(rd_cnt) : '0;
      end
      if (phase_n == ST_READY) setup_done <= 1'b1;
      if (id_load) begin
        own_id    <= msg_data[15:0];
        is_master <= (master_mode == MODE_ON) ||
                     ((master_mode == MODE_AUTO) && (msg_data[15:0] == 16'd0));
      end
      if (grow) peer_count <= TW'(32'(cls.idx) + 32'd1);
      if (raise && !err_flag) begin
        err_flag <= 1'b1;
        err_code <= code;
      end
    end
  end
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int NPEER = 16,
  parameter int NVEC  = 8,
  localparam int PW = (NPEER > 1) ? $clog2(NPEER) : 1,
  localparam int VW = (NVEC > 1) ? $clog2(NVEC) : 1,
  localparam int TW = $clog2(NPEER + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          setup_done,
  input logic [TW-1:0] peer_count,
  input logic          err_flag,
  input logic [2:0]    err_code,
  input logic          conn_valid,
  input logic          disc_valid,
  input logic [PW-1:0] ev_peer,
  input logic [VW-1:0] ev_vector
);
  // R13
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(conn_valid && disc_valid));

  // R7
  conn_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    conn_valid |=> !conn_valid);

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> (err_flag && $stable(err_code)));

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    setup_done |=> setup_done);

  // R11
  table_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (peer_count != '0) |=> (peer_count >= $past(peer_count)));

  // R2
  fatal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (conn_valid || disc_valid) |-> (err_code != 3'd1 && err_code != 3'd2));
endmodule

bind peer_setup_seq pss_checker #(.NPEER(NPEER), .NVEC(NVEC)) u_pss_chk (
  .clk(clk), .rst(rst), .setup_done(setup_done), .peer_count(peer_count),
  .err_flag(err_flag), .err_code(err_code), .conn_valid(conn_valid),
  .disc_valid(disc_valid), .ev_peer(ev_peer), .ev_vector(ev_vector)
);

// File: tb/tb_peer_setup_seq.sv
module tb_peer_setup_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NPEER = 4;
  localparam int NVEC  = 2;
  localparam int PW = 2;
  localparam int VW = 1;
  localparam int TW = 3;

  logic clk = 1'b0;
  logic rst;
  logic [1:0] master_mode;
  logic in_valid, in_handle;
  logic [7:0] in_byte;
  logic setup_done, is_master, err_flag, conn_valid, disc_valid;
  logic [15:0] own_id;
  logic [TW-1:0] peer_count;
  logic [2:0] err_code;
  logic [PW-1:0] ev_peer;
  logic [VW-1:0] ev_vector;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct { bit conn; int peer; int vec; } ev_t;
  ev_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  peer_setup_seq #(.NPEER(NPEER), .NVEC(NVEC), .PROTO_VER(64'd0)) dut (
    .clk(clk), .rst(rst), .master_mode(master_mode), .in_valid(in_valid),
    .in_byte(in_byte), .in_handle(in_handle), .setup_done(setup_done),
    .is_master(is_master), .own_id(own_id), .peer_count(peer_count),
    .err_flag(err_flag), .err_code(err_code), .conn_valid(conn_valid),
    .disc_valid(disc_valid), .ev_peer(ev_peer), .ev_vector(ev_vector)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops expected events and compares
  always @(negedge clk) begin
    if (!rst && (conn_valid || disc_valid)) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R13 unexpected event actual=peer%0d expected=none", ev_peer);
      end else begin
        ev_t e;
        e = expq.pop_front();
        chk(e.conn ? "R7 event kind" : "R9 event kind", conn_valid, e.conn);
        chk(e.conn ? "R7 peer" : "R9 peer", ev_peer, e.peer);
        chk(e.conn ? "R7 vector" : "R9 vector", ev_vector, e.vec);
      end
    end
  end

  task automatic expect_ev(input bit c, input int p, input int v);
    ev_t e;
    e.conn = c; e.peer = p; e.vec = v;
    expq.push_back(e);
  endtask

  task automatic send_msg(input longint v, input bit h, input int gap);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_byte   = v[8*i +: 8];
      in_handle = (i == 7) ? h : 1'b1;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_handle = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    chk("R7 R9 pending events drained", expq.size(), 0);
    expq.delete();
    master_mode = m;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] m, input longint id);
    do_reset(m);
    send_msg(0, 0, 0);
    send_msg(id, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL R13 watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    in_valid = 0; in_byte = 0; in_handle = 0; master_mode = 2; rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 setup_done in reset", setup_done, 0);
    chk("R12 err_flag in reset", err_flag, 0);
    chk("R13 conn_valid in reset", conn_valid, 0);
    chk("R11 peer_count in reset", peer_count, 0);
    rst = 1'b0;
    @(negedge clk);

    // main flow, version sent with idle gaps (R1)
    send_msg(0, 0, 2);
    send_msg(0, 0, 0);
    chk("R2 version accepted", err_flag, 0);
    chk("R3 own_id", own_id, 0);
    chk("R4 auto master id0", is_master, 1);
    expect_ev(1, 3, 0); send_msg(3, 1, 0);
    chk("R11 grow to 4", peer_count, 4);
    expect_ev(1, 3, 1); send_msg(3, 1, 1);
    expect_ev(1, 0, 0); send_msg(0, 1, 0);
    expect_ev(0, 3, 0); send_msg(3, 0, 0);
    expect_ev(1, 3, 0); send_msg(3, 1, 0);
    chk("R5 not done before shmem", setup_done, 0);
    send_msg(-1, 0, 0);
    chk("R5 done after shmem", setup_done, 1);
    expect_ev(1, 1, 0); send_msg(1, 1, 0);
    chk("R11 no shrink", peer_count, 4);
    chk("R12 no error in clean run", err_flag, 0);

    // own disconnect, then sticky
    setup(2, 1);
    chk("R4 auto master id1", is_master, 0);
    send_msg(1, 0, 0);
    chk("R9 own disconnect code", err_code, 5);
    expect_ev(0, 2, 0); send_msg(2, 0, 0);
    chk("R11 grow by disconnect", peer_count, 3);
    expect_ev(1, 2, 0); send_msg(2, 1, 0);
    expect_ev(1, 2, 1); send_msg(2, 1, 0);
    send_msg(2, 1, 0);
    chk("R12 first code kept", err_code, 5);
    chk("R12 flag sticky", err_flag, 1);

    // vector overflow
    setup(2, 0);
    expect_ev(1, 1, 0); send_msg(1, 1, 0);
    expect_ev(1, 1, 1); send_msg(1, 1, 0);
    send_msg(1, 1, 0);
    chk("R8 overflow code", err_code, 4);
    expect_ev(0, 1, 0); send_msg(1, 0, 0);
    expect_ev(1, 1, 0); send_msg(1, 1, 0);

    // range errors
    setup(2, 0);
    send_msg(-5, 1, 0);
    chk("R6 below -1", err_code, 3);
    chk("R6 no growth", peer_count, 0);
    expect_ev(1, 0, 0); send_msg(0, 1, 0);
    setup(2, 0);
    send_msg(70000, 0, 0);
    chk("R6 above 65535", err_code, 3);

    // capacity
    setup(2, 0);
    send_msg(9, 1, 0);
    chk("R10 capacity code", err_code, 7);
    chk("R10 no growth", peer_count, 0);
    send_msg(65535, 0, 0);
    chk("R10 top index no growth", peer_count, 0);

    // duplicate shmem
    setup(2, 0);
    send_msg(-1, 0, 0);
    send_msg(-1, 0, 0);
    chk("R5 duplicate shmem code", err_code, 6);
    chk("R5 done stays", setup_done, 1);

    // bad version value
    do_reset(2);
    send_msg(3, 0, 0);
    chk("R2 bad version code", err_code, 1);
    send_msg(0, 0, 0);
    send_msg(1, 1, 0);
    send_msg(-1, 0, 0);
    chk("R2 fatal no done", setup_done, 0);
    chk("R2 fatal no growth", peer_count, 0);

    // version with handle
    do_reset(2);
    send_msg(0, 1, 0);
    chk("R2 version handle code", err_code, 1);

    // ID errors
    do_reset(2);
    send_msg(0, 0, 0);
    send_msg(0, 1, 0);
    chk("R3 id handle code", err_code, 2);
    do_reset(2);
    send_msg(0, 0, 0);
    send_msg(70000, 0, 0);
    chk("R3 id range code", err_code, 2);

    // master modes
    setup(1, 1);
    chk("R4 forced with id1 code", err_code, 2);
    chk("R4 forced fail no master", is_master, 0);
    setup(1, 0);
    chk("R4 forced id0 master", is_master, 1);
    chk("R4 forced id0 no error", err_flag, 0);
    setup(0, 0);
    chk("R4 off id0 not master", is_master, 0);

    // byte order
    setup(2, 258);
    chk("R1 little-endian id", own_id, 258);
    chk("R1 handle only on last beat", err_flag, 0);

    do_reset(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule